// File: doc/BRIEF.md
# Two-Level Trace Frequency Filter

This block counts how often each trace identifier is seen and promotes frequent identifiers in two steps. Events arrive one per cycle as an identifier plus a source bit. A source of 0 means the trace was formed from code that completed on the cold path. A source of 1 means the trace ran on the hot path. Cold events train a first table. When an identifier's count there reaches the cold limit, the block raises a build request carrying that identifier. Hot events train a second, separate table. Reaching the hot limit there raises an optimise request, so the trace can be optimised and rewritten in place.

Both tables have the same structure. Each is a set-associative cache of identifier tags. The set is picked by the low identifier bits, and a way is replaced by true LRU when a new identifier misses. Each entry holds a saturating counter and a promoted flag. Once an entry has promoted, it keeps counting but never requests again. Both limits come in on ports and can be changed at run time. Typical values are 16 for the cold limit and 64 for the hot limit. A limit of 0 acts as 1.

Top module: `trace_heat_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `build_req` and `opt_req` are both 0.
- R2: An event with `evt_hot`=0 trains only the cold table, and one with `evt_hot`=1 trains only the hot table. A build request only follows a cold event, and an optimise request only follows a hot event.
- R3: Each cold event adds one to its identifier's count. In the cycle after the event that brings the count up to `cold_limit`, `build_req` is 1 and `build_tid` equals that event's identifier. This holds for back-to-back events as well.
- R4: In the cycle after the hot event that brings an identifier's hot count up to `hot_limit`, `opt_req` is 1 and `opt_tid` equals that identifier.
- R5: After an entry has raised its request, further events for the same identifier raise no further request while the entry stays resident.
- R6: A cycle with `evt_vld`=0 changes no count, whatever `evt_tid` and `evt_hot` hold.
- R7: A miss allocates the entry with a count of one, so a limit of 1 promotes on the identifier's first event.
- R8: The set index is the low log2(SETS) bits of the identifier. On a miss in a full set, the least recently accessed way is replaced, and the replaced identifier's count is lost.
- R9: Events that map to one set never evict or change entries in another set.
- R10: Each request pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_vld | input | 1 | An event is present this cycle |
| evt_hot | input | 1 | Event source: 0 cold path, 1 hot path |
| evt_tid | input | TID_W | Trace identifier of the event |
| cold_limit | input | CNT_W | Count at which a cold-path identifier is promoted |
| hot_limit | input | CNT_W | Count at which a hot-path identifier is promoted |
| build_req | output | 1 | One-cycle request to construct and insert a trace |
| build_tid | output | TID_W | Identifier for the build request |
| opt_req | output | 1 | One-cycle request to optimise and replace a trace |
| opt_tid | output | TID_W | Identifier for the optimise request |

## Verification
The bench builds the block with TID_W=6, SETS=2, WAYS=2 and CNT_W=4. With only two sets of two ways, a handful of identifiers with equal low bits is enough to fill a set. That brings LRU victim choice, the loss of an evicted count and re-allocation within reach of short directed sequences. Because the limits are ports, the same build also covers a limit of 1, a promotion at three events, and a hot promotion after an interleaved cold event.

// File: rtl/thf_pkg.sv
`timescale 1ns/1ps
package thf_pkg;
  typedef enum logic {
    SRC_COLD = 1'b0,
    SRC_HOT  = 1'b1
  } thf_src_e;
endpackage

// File: rtl/thf_victim.sv
`timescale 1ns/1ps
// Picks the way to fill on a miss: lowest invalid way, else the oldest way.
module thf_victim #(
  parameter int WAYS  = 4,
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             way_vld,
  input  logic [WAYS-1:0][AGE_W-1:0]  way_age,
  output logic [AGE_W-1:0]            victim
);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  always_comb begin
    victim = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_age[w] == OLDEST) victim = AGE_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) victim = AGE_W'(w);
    end
  end
endmodule

// File: rtl/thf_table.sv
`timescale 1ns/1ps
// One filter level: set-associative tags with saturating counters.
module thf_table #(
  parameter int TID_W = 16,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_vld,
  input  logic [TID_W-1:0] ev_tid,
  input  logic [CNT_W-1:0] limit,
  output logic             prom_req,
  output logic [TID_W-1:0] prom_tid
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = TID_W - IDX_W;
  localparam int AGE_W = $clog2(WAYS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SETS-1:0][WAYS-1:0]            vld_q, prom_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][CNT_W-1:0] cnt_q;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

  logic [IDX_W-1:0]            idx;
  logic [TAG_W-1:0]            tag;
  logic                        hit;
  logic [AGE_W-1:0]            hit_way, vic_way, sel_way, ref_age;
  logic [CNT_W-1:0]            old_cnt, new_cnt;
  logic                        old_prom, new_prom, fire;
  logic [WAYS-1:0][AGE_W-1:0]  new_age;
  logic                        pulse_q;
  logic [TID_W-1:0]            tid_q;

  assign idx = ev_tid[IDX_W-1:0];
  assign tag = ev_tid[TID_W-1:IDX_W];

  thf_victim #(.WAYS(WAYS), .AGE_W(AGE_W)) u_victim (
    .way_vld (vld_q[idx]),
    .way_age (age_q[idx]),
    .victim  (vic_way)
  );

  // Lookup and next-state of the addressed entry
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[idx][w] && tag_q[idx][w] == tag) begin
        hit     = 1'b1;
        hit_way = AGE_W'(w);
      end
    end
    sel_way  = hit ? hit_way : vic_way;
    old_cnt  = hit ? cnt_q[idx][sel_way] : '0;
    old_prom = hit && prom_q[idx][sel_way];
    new_cnt  = (old_cnt == CNT_MAX) ? old_cnt : old_cnt + 1'b1;
    fire     = ev_vld && !old_prom && (new_cnt >= limit);
    new_prom = old_prom || fire;
    ref_age  = age_q[idx][sel_way];
    for (int w = 0; w < WAYS; w++) begin
      if (sel_way == AGE_W'(w))        new_age[w] = '0;
      else if (age_q[idx][w] < ref_age) new_age[w] = age_q[idx][w] + 1'b1;
      else                              new_age[w] = age_q[idx][w];
    end
  end

  // Table storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      prom_q <= '0;
      tag_q  <= '0;
      cnt_q  <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (ev_vld) begin
      vld_q[idx][sel_way]  <= 1'b1;
      prom_q[idx][sel_way] <= new_prom;
      tag_q[idx][sel_way]  <= tag;
      cnt_q[idx][sel_way]  <= new_cnt;
      age_q[idx]           <= new_age;
    end
  end

  // Promotion output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      tid_q   <= '0;
    end else begin
      pulse_q <= fire;
      if (ev_vld) tid_q <= ev_tid;
    end
  end

  assign prom_req = pulse_q;
  assign prom_tid = tid_q;
endmodule

// File: rtl/trace_heat_filter.sv
`timescale 1ns/1ps
module trace_heat_filter #(
  parameter int TID_W = 16,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_vld,
  input  logic             evt_hot,
  input  logic [TID_W-1:0] evt_tid,
  input  logic [CNT_W-1:0] cold_limit,
  input  logic [CNT_W-1:0] hot_limit,
  output logic             build_req,
  output logic [TID_W-1:0] build_tid,
  output logic             opt_req,
  output logic [TID_W-1:0] opt_tid
);
  import thf_pkg::*;

  thf_src_e src;
  logic     cold_ev, hot_ev;

  assign src     = thf_src_e'(evt_hot);
  assign cold_ev = evt_vld && (src == SRC_COLD);
  assign hot_ev  = evt_vld && (src == SRC_HOT);

  thf_table #(.TID_W(TID_W), .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_cold (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_vld   (cold_ev),
    .ev_tid   (evt_tid),
    .limit    (cold_limit),
    .prom_req (build_req),
    .prom_tid (build_tid)
  );

  thf_table #(.TID_W(TID_W), .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_hot (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_vld   (hot_ev),
    .ev_tid   (evt_tid),
    .limit    (hot_limit),
    .prom_req (opt_req),
    .prom_tid (opt_tid)
  );
endmodule

// File: rtl/trace_heat_filter_chk.sv
`timescale 1ns/1ps
module trace_heat_filter_chk #(
  parameter int TID_W = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_vld,
  input logic             evt_hot,
  input logic [TID_W-1:0] evt_tid,
  input logic             build_req,
  input logic [TID_W-1:0] build_tid,
  input logic             opt_req,
  input logic [TID_W-1:0] opt_tid
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_idle_chk: assert (!build_req && !opt_req);
  end

  // R2
  cold_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_vld && !evt_hot) |=> !build_req);

  // R2
  hot_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_vld && evt_hot) |=> !opt_req);

  // R3
  build_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && !evt_hot) |=> (!build_req || build_tid == $past(evt_tid)));

  // R4
  opt_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && evt_hot) |=> (!opt_req || opt_tid == $past(evt_tid)));

  // R2
  one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(build_req && opt_req));
endmodule

bind trace_heat_filter trace_heat_filter_chk #(.TID_W(TID_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_vld   (evt_vld),
  .evt_hot   (evt_hot),
  .evt_tid   (evt_tid),
  .build_req (build_req),
  .build_tid (build_tid),
  .opt_req   (opt_req),
  .opt_tid   (opt_tid)
);

// File: tb/test_trace_heat_filter.sv
`timescale 1ns/1ps
module test_trace_heat_filter;
  localparam int TID_W = 6;
  localparam int CNT_W = 4;

  logic             clk;
  logic             rst_n;
  logic             evt_vld;
  logic             evt_hot;
  logic [TID_W-1:0] evt_tid;
  logic [CNT_W-1:0] cold_limit;
  logic [CNT_W-1:0] hot_limit;
  logic             build_req;
  logic [TID_W-1:0] build_tid;
  logic             opt_req;
  logic [TID_W-1:0] opt_tid;

  int checks = 0;
  int errors = 0;

  trace_heat_filter #(.TID_W(TID_W), .SETS(2), .WAYS(2), .CNT_W(CNT_W)) i_trace_heat_filter (
    .clk(clk), .rst_n(rst_n), .evt_vld(evt_vld), .evt_hot(evt_hot), .evt_tid(evt_tid),
    .cold_limit(cold_limit), .hot_limit(hot_limit),
    .build_req(build_req), .build_tid(build_tid), .opt_req(opt_req), .opt_tid(opt_tid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare both request outputs with the expected values
  task automatic check_out(input string req, input bit eb, input bit eo, input int tid);
    check(build_req == eb, req, "build_req", int'(build_req), int'(eb));
    if (eb) check(build_tid == TID_W'(tid), req, "build_tid", int'(build_tid), tid);
    check(opt_req == eo, req, "opt_req", int'(opt_req), int'(eo));
    if (eo) check(opt_tid == TID_W'(tid), req, "opt_tid", int'(opt_tid), tid);
  endtask

  // One event, its result one cycle later, then one idle cycle (R10)
  task automatic ev(input bit hot, input int tid, input bit eb, input bit eo, input string req);
    @(negedge clk);
    evt_vld = 1'b1; evt_hot = hot; evt_tid = TID_W'(tid);
    @(posedge clk); #1;
    check_out(req, eb, eo, tid);
    @(negedge clk);
    evt_vld = 1'b0;
    @(posedge clk); #1;
    check_out("R10", 1'b0, 1'b0, tid);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; evt_vld = 1'b0; evt_hot = 1'b0; evt_tid = '0;
    cold_limit = 4'd3; hot_limit = 4'd2;
    repeat (3) @(posedge clk);
    #1 check_out("R1", 1'b0, 1'b0, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check_out("R1", 1'b0, 1'b0, 0);
  endtask

  task automatic t_cold_promote();
    cold_limit = 4'd3;
    ev(1'b0, 'h10, 1'b0, 1'b0, "R3");
    ev(1'b0, 'h10, 1'b0, 1'b0, "R3");
    ev(1'b0, 'h10, 1'b1, 1'b0, "R3");
    ev(1'b0, 'h10, 1'b0, 1'b0, "R5");
    ev(1'b0, 'h10, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_hot_promote();
    hot_limit = 4'd2;
    ev(1'b1, 'h10, 1'b0, 1'b0, "R4");
    ev(1'b1, 'h10, 1'b0, 1'b1, "R4");
    ev(1'b1, 'h10, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_routing();
    hot_limit = 4'd2; cold_limit = 4'd3;
    ev(1'b1, 'h23, 1'b0, 1'b0, "R2");
    ev(1'b0, 'h23, 1'b0, 1'b0, "R2");   // cold count 1, hot count stays 1
    ev(1'b1, 'h23, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_ignore();
    cold_limit = 4'd3;
    @(negedge clk);
    evt_vld = 1'b0;
    for (int i = 0; i < 6; i++) begin
      evt_tid = TID_W'('h05); evt_hot = i[0];
      @(posedge clk); #1;
      check_out("R6", 1'b0, 1'b0, 'h05);
      @(negedge clk);
    end
    ev(1'b0, 'h05, 1'b0, 1'b0, "R6");
    ev(1'b0, 'h05, 1'b0, 1'b0, "R6");
    ev(1'b0, 'h05, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_alloc();
    cold_limit = 4'd1;
    ev(1'b0, 'h07, 1'b1, 1'b0, "R7");
    ev(1'b0, 'h07, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_lru();
    cold_limit = 4'd3;
    ev(1'b0, 'h02, 1'b0, 1'b0, "R8");
    ev(1'b0, 'h04, 1'b0, 1'b0, "R8");
    ev(1'b0, 'h04, 1'b0, 1'b0, "R8");
    ev(1'b0, 'h08, 1'b0, 1'b0, "R8");   // evicts 02
    ev(1'b0, 'h04, 1'b1, 1'b0, "R8");   // 04 kept its count
    ev(1'b0, 'h02, 1'b0, 1'b0, "R8");   // 02 restarts at one, evicts 08
    ev(1'b0, 'h02, 1'b0, 1'b0, "R8");
    ev(1'b0, 'h02, 1'b1, 1'b0, "R8");
  endtask

  task automatic t_sets();
    cold_limit = 4'd2;
    ev(1'b0, 'h31, 1'b0, 1'b0, "R9");
    ev(1'b0, 'h0A, 1'b0, 1'b0, "R9");
    ev(1'b0, 'h0C, 1'b0, 1'b0, "R9");
    ev(1'b0, 'h0E, 1'b0, 1'b0, "R9");
    ev(1'b0, 'h12, 1'b0, 1'b0, "R9");
    ev(1'b0, 'h31, 1'b1, 1'b0, "R9");
  endtask

  task automatic t_back_to_back();
    cold_limit = 4'd3;
    @(negedge clk);
    evt_vld = 1'b1; evt_hot = 1'b0; evt_tid = TID_W'('h2B);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check_out("R3", i == 2, 1'b0, 'h2B);
      @(negedge clk);
    end
    evt_vld = 1'b0;
    @(posedge clk); #1;
    check_out("R10", 1'b0, 1'b0, 'h2B);
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_cold_promote();
    t_hot_promote();
    t_routing();
    t_ignore();
    t_alloc();
    t_lru();
    t_sets();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule